// File: doc/BRIEF.md
# Disk Read Bit Shifter with Sync Detection

This block sits behind a disk data separator. Each recovered data bit arrives with a one-cycle valid strobe. The block shifts the bit into a 16-bit assembly register and keeps a count of bits within the current word. When a word boundary is reached, it presents the assembled word together with a flag that says whether that word equals the programmed sync pattern. On every bit that completes a match, it also raises a one-cycle sync interrupt pulse, whether or not the match falls on a word boundary.

Word alignment can be restored in two ways. When sync mode is enabled, a sync match restarts the bit count, so the matching word is delivered at once and the next word follows sixteen bits later. An index pulse from the drive always restarts the count and is forwarded as a one-cycle flag. A control register holds the sync-mode enable and the bit-cell rate select. The rate select is exported as a single level for the data separator.

Top module: `dsk_bitshift`

## Requirements
- R1: After reset the outputs are all low, the bit count is zero, the assembly register and the sync pattern register both hold 0x0000, and both control bits are clear. As a result, a first received bit of 0 matches the sync pattern.
- R2: A bit with `bit_vld` high enters the assembly register at bit 0, and the older bits move one place toward bit 15. The word presented therefore holds the earliest of its 16 bits in bit 15.
- R3: Without realignment, a word is presented (`word_vld` high for one cycle, the cycle after the bit) on every 16th valid bit, and at no other time.
- R4: `sync_irq` pulses high for one cycle, the cycle after any valid bit that makes the assembly register equal the sync pattern. This happens whatever the sync-mode setting.
- R5: `word_sync` is high with a presented word exactly when that word equals the sync pattern.
- R6: With control bit 10 set (sync mode), a match restarts the count. The matching word is presented in the next cycle, and the following word comes 16 valid bits later.
- R7: With control bit 10 clear, a match raises `sync_irq` but leaves the word boundary where it was.
- R8: `index_pulse` produces a one-cycle `index_flag` in the next cycle and restarts the count, so the next word is presented 16 valid bits later. If a valid bit arrives in the same cycle as the index pulse, the index takes precedence and that bit's word is presented at once.
- R9: `fast_cell` follows control bit 8 from the cycle after a control write: 1 selects the 2 µs cell and 0 the 4 µs cell. All control bits other than 10 and 8 have no effect.
- R10: Cycles with `bit_vld` low neither shift nor count, and they produce no word and no sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | A recovered data bit is present this cycle |
| bit_val | input | 1 | Value of the recovered bit |
| index_pulse | input | 1 | Index hole seen by the drive |
| sync_wr | input | 1 | Write strobe for the sync pattern |
| sync_wdata | input | 16 | New sync pattern |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 16 | New control value (bit 10 sync mode, bit 8 fast cell) |
| word_vld | output | 1 | Assembled word presented this cycle |
| word_data | output | 16 | Assembled word |
| word_sync | output | 1 | Presented word equals the sync pattern |
| sync_irq | output | 1 | One-cycle sync match pulse |
| index_flag | output | 1 | One-cycle copy of the index pulse |
| fast_cell | output | 1 | Bit-cell rate select for the data separator |

## Verification
The bench places the sync pattern at an odd bit offset, with sync mode both off and on. A design that realigns regardless of the mode would drift its boundaries off the 16-bit grid. A design that never realigns would present the sync word late or not at all. Index pulses arrive both alone and together with a bit. A design that gives the bit precedence would present that word one bit later than expected. Idle gaps are inserted between bits to catch a counter that advances without a valid strobe. The first bit after reset is a zero, which catches a nonzero reset value in either the assembly register or the pattern register.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  localparam int SYNC_EN_POS = 10;
  localparam int FAST_POS    = 8;

  typedef struct packed {
    logic sync_en;
    logic fast;
  } dsk_cfg_t;
endpackage

// File: rtl/dsk_cfg_regs.sv
module dsk_cfg_regs
  import dsk_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_wr,
  input  logic [WORD_W-1:0] sync_wdata,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [WORD_W-1:0] sync_word,
  output dsk_cfg_t          cfg
);
  function automatic dsk_cfg_t decode_ctrl(input logic [CTRL_W-1:0] v);
    dsk_cfg_t c;
    c.sync_en = v[SYNC_EN_POS];
    c.fast    = v[FAST_POS];
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_word <= '0;
      cfg       <= '0;
    end else begin
      if (sync_wr) sync_word <= sync_wdata;
      if (ctrl_wr) cfg <= decode_ctrl(ctrl_wdata);
    end
  end
endmodule

// File: rtl/dsk_sync_cmp.sv
module dsk_sync_cmp #(
  parameter int WORD_W = 16
) (
  input  logic              bit_vld,
  input  logic [WORD_W-1:0] word_next,
  input  logic [WORD_W-1:0] pattern,
  output logic              match
);
  logic [WORD_W-1:0] bit_eq;

  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_eq
      assign bit_eq[i] = ~(word_next[i] ^ pattern[i]);
    end
  endgenerate

  assign match = bit_vld & (&bit_eq);
endmodule

// File: rtl/dsk_word_cnt.sv
module dsk_word_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             realign,
  input  logic             index_pulse,
  output logic [CNT_W-1:0] cnt_next,
  output logic             boundary
);
  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] c, input logic vld, input logic ra, input logic idx);
    if (idx || ra) return '0;
    if (vld)       return c + 1'b1;
    return c;
  endfunction

  assign cnt_next = step_count(cnt, bit_vld, realign, index_pulse);
  assign boundary = bit_vld && (cnt_next == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_next;
  end
endmodule

// File: rtl/dsk_bitshift.sv
module dsk_bitshift
  import dsk_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic              index_pulse,
  input  logic              sync_wr,
  input  logic [WORD_W-1:0] sync_wdata,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_data,
  output logic              word_sync,
  output logic              sync_irq,
  output logic              index_flag,
  output logic              fast_cell
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] shreg_next;
  logic [WORD_W-1:0] sync_word;
  dsk_cfg_t          cfg;
  logic              match_w;
  logic              realign_w;
  logic              boundary_w;
  logic [CNT_W-1:0]  cnt_next_w;

  function automatic logic [WORD_W-1:0] shift_in(
    input logic [WORD_W-1:0] w, input logic b);
    return {w[WORD_W-2:0], b};
  endfunction

  assign shreg_next = bit_vld ? shift_in(shreg, bit_val) : shreg;
  assign realign_w  = match_w & cfg.sync_en;
  assign fast_cell  = cfg.fast;

  dsk_cfg_regs #(.WORD_W(WORD_W), .CTRL_W(CTRL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .sync_wr(sync_wr), .sync_wdata(sync_wdata),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .sync_word(sync_word), .cfg(cfg)
  );

  dsk_sync_cmp #(.WORD_W(WORD_W)) u_cmp (
    .bit_vld(bit_vld), .word_next(shreg_next),
    .pattern(sync_word), .match(match_w)
  );

  dsk_word_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld),
    .realign(realign_w), .index_pulse(index_pulse),
    .cnt_next(cnt_next_w), .boundary(boundary_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg      <= '0;
      word_vld   <= 1'b0;
      word_data  <= '0;
      word_sync  <= 1'b0;
      sync_irq   <= 1'b0;
      index_flag <= 1'b0;
    end else begin
      shreg      <= shreg_next;
      word_vld   <= boundary_w;
      word_sync  <= boundary_w & match_w;
      sync_irq   <= match_w;
      index_flag <= index_pulse;
      if (boundary_w) word_data <= shreg_next;
    end
  end
endmodule

// File: rtl/dsk_bitshift_chk.sv
module dsk_bitshift_chk #(
  parameter int CTRL_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_vld,
  input logic              index_pulse,
  input logic              ctrl_wr,
  input logic [CTRL_W-1:0] ctrl_wdata,
  input logic              word_vld,
  input logic              word_sync,
  input logic              sync_irq,
  input logic              index_flag,
  input logic              fast_cell,
  input logic              realign_w
);
  // R4: a sync pulse always follows a valid bit
  a_r4_irq_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    sync_irq |-> $past(bit_vld));

  // R5: the word flag agrees with the match pulse of the same bit
  a_r5_flag_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> (word_sync == sync_irq));

  // R6: a realigning match presents its word in the next cycle
  a_r6_realign_emits: assert property (@(posedge clk) disable iff (!rst_n)
    realign_w |=> (word_vld && word_sync));

  // R8: index is forwarded one cycle later
  a_r8_index_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    index_pulse |=> index_flag);

  a_r8_index_only: assert property (@(posedge clk) disable iff (!rst_n)
    index_flag |-> $past(index_pulse));

  // R9: rate select follows bit 8 of a control write
  a_r9_fast_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (fast_cell == $past(ctrl_wdata[8])));

  // R10: idle cycles produce neither a word nor a pulse
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> (!word_vld && !sync_irq));
endmodule

bind dsk_bitshift dsk_bitshift_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .index_pulse(index_pulse),
  .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .word_vld(word_vld),
  .word_sync(word_sync), .sync_irq(sync_irq), .index_flag(index_flag),
  .fast_cell(fast_cell), .realign_w(realign_w)
);

// File: tb/tb_dsk_bitshift.sv
`timescale 1ns/1ps
module tb_dsk_bitshift;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_vld = 1'b0, bit_val = 1'b0, index_pulse = 1'b0;
  logic        sync_wr = 1'b0, ctrl_wr = 1'b0;
  logic [15:0] sync_wdata = '0, ctrl_wdata = '0;
  logic        word_vld, word_sync, sync_irq, index_flag, fast_cell;
  logic [15:0] word_data;

  always #2.5 clk = ~clk;

  dsk_bitshift dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .index_pulse(index_pulse), .sync_wr(sync_wr), .sync_wdata(sync_wdata),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .word_vld(word_vld),
    .word_data(word_data), .word_sync(word_sync), .sync_irq(sync_irq),
    .index_flag(index_flag), .fast_cell(fast_cell)
  );

  typedef struct {
    logic        vld;
    logic [15:0] data;
    logic        sync;
    logic        irq;
    logic        idx;
    logic        fast;
    string       tag;
  } exp_t;

  exp_t  q[$];
  int    checks = 0, errors = 0;
  bit    done = 0;
  string tag = "R1";

  // bench model of the requirements
  logic [15:0] m_sr = '0, m_pat = '0;
  int          m_bits = 0;
  bit          m_sen = 0, m_fast = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, expv);
    end
  endtask

  task automatic step(input bit v, input bit b, input bit idx);
    exp_t e;
    bit   hit;
    @(negedge clk);
    bit_vld = v; bit_val = b; index_pulse = idx;
    hit = 0;
    e.vld = 0; e.sync = 0;
    if (v) begin
      m_sr = {m_sr[14:0], b};
      hit  = (m_sr == m_pat);
      m_bits = m_bits + 1;
    end
    if (idx || (hit && m_sen)) m_bits = v ? 16 : 0;
    if (v && m_bits == 16) begin
      e.vld = 1; e.sync = hit; m_bits = 0;
    end
    e.data = m_sr; e.irq = hit; e.idx = idx; e.fast = m_fast; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic send_word(input logic [15:0] w, input bit gaps);
    for (int i = 15; i >= 0; i--) begin
      step(1, w[i], 0);
      if (gaps && (i % 5 == 0)) idle(1);
    end
  endtask

  task automatic send_rand(input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(1, lfsr[0], 0);
    end
  endtask

  task automatic wr_sync(input logic [15:0] v);
    exp_t e;
    @(negedge clk);
    bit_vld = 0; index_pulse = 0; sync_wr = 1; sync_wdata = v;
    m_pat = v;
    e.vld = 0; e.data = m_sr; e.sync = 0; e.irq = 0; e.idx = 0; e.fast = m_fast; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    sync_wr = 0;
    e.tag = tag; q.push_back(e);
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    exp_t e;
    @(negedge clk);
    bit_vld = 0; index_pulse = 0; ctrl_wr = 1; ctrl_wdata = v;
    m_sen = v[10]; m_fast = v[8];
    e.vld = 0; e.data = m_sr; e.sync = 0; e.irq = 0; e.idx = 0; e.fast = m_fast; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    ctrl_wr = 0;
    q.push_back(e);
  endtask

  // monitor: compare one expected item per cycle
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk({e.tag, " word_vld"}, word_vld, e.vld);
        if (e.vld) begin
          chk({e.tag, " word_data"}, word_data, e.data);
          chk({e.tag, " word_sync"}, word_sync, e.sync);
        end
        chk({e.tag, " sync_irq"}, sync_irq, e.irq);
        chk({e.tag, " index_flag"}, index_flag, e.idx);
        chk({e.tag, " fast_cell"}, fast_cell, e.fast);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset values at the ports
    chk("R1 word_vld", word_vld, 0);
    chk("R1 sync_irq", sync_irq, 0);
    chk("R1 index_flag", index_flag, 0);
    chk("R1 fast_cell", fast_cell, 0);
    chk("R1 word_data", word_data, 0);
    rst_n = 1;
    // R1: zero register meets zero pattern on a first 0 bit
    tag = "R1"; step(1, 0, 0);
    // R9: control bit 8 and ignored bits
    tag = "R9"; wr_ctrl(16'h0100);
    wr_ctrl(16'hFAFF);
    wr_ctrl(16'h0000);
    wr_sync(16'h4489);
    // realign grid with index, then plain words R2, R3, R10
    tag = "R8"; step(0, 0, 1);
    tag = "R2"; send_word(16'hA5C3, 0);
    send_word(16'h0F1E, 0);
    tag = "R10"; send_word(16'h8001, 1);
    tag = "R3"; send_rand(40);
    // R7: pattern at odd offset, sync mode off
    tag = "R7"; send_rand(3);
    send_word(16'h4489, 0);
    send_rand(29);
    // R4, R5: pattern on a boundary
    tag = "R5"; step(0, 0, 1);
    send_word(16'h4489, 0);
    tag = "R4"; send_rand(16);
    // R6: sync mode on
    tag = "R6"; wr_ctrl(16'h0400);
    send_rand(5);
    send_word(16'h4489, 0);
    send_word(16'h1234, 1);
    send_word(16'h4489, 0);
    send_rand(21);
    // R8: index alone and with a bit
    tag = "R8"; wr_ctrl(16'h0100);
    send_rand(7);
    step(0, 0, 1);
    send_rand(20);
    step(1, 1, 1);
    send_rand(33);
    idle(3);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule